// File: doc/BRIEF.md
# Exactly-Two Marked-Symbol Recognizer

This block reads a stream of one-bit symbols, one per rising clock edge when a valid strobe is high, and raises an accept flag whenever the symbols taken since the last reset contain exactly two copies of the marked letter. The letter `a` is encoded as 0 and the marked letter `b` as 1. Only `b` symbols count toward the total. `a` symbols and idle cycles leave the count unchanged.

The machine counts `b` symbols in a small state register. Once a third `b` arrives, it falls into an overflow state and stays there until reset. The next state comes from a set of small per-state functions. The current state selects one of them through a multiplexer. The accept flag is decoded from the registered state alone, so it changes only at a clock edge.

Top module: `pairRecognizer`

## Requirements
- R1: A synchronous active-high reset, sampled at a rising edge, puts the machine in state 0 (empty string). `accept` is 0 after that edge.
- R2: A valid symbol 0 (`a`) leaves the state unchanged, so `accept` keeps its value.
- R3: A valid symbol 1 (`b`) in state 0, 1 or 2 moves the state to the next number. `accept` is 1 exactly when the state is 2, that is, after the second `b`.
- R4: A third valid `b` moves the machine to overflow state 3, and `accept` returns to 0.
- R5: State 3 is absorbing. Any valid symbol, 0 or 1, leaves the machine in state 3 with `accept` at 0 until a reset.
- R6: While `symValid` is 0, the state is held whatever `symBit` carries.
- R7: `accept` depends only on the registered state. A change on `symValid` or `symBit` between clock edges does not change it.
- R8: Reset takes priority over a valid symbol presented at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | Symbol strobe; the symbol is taken only when high |
| symBit | input | 1 | Symbol, 0 = `a`, 1 = `b` |
| accept | output | 1 | High when exactly two `b` symbols have been taken |

## Verification
The following input patterns are applied:
- Runs of `a` only. These confirm that non-marked symbols never move the count.
- Two `b` symbols with `a` symbols between them. This shows that acceptance follows the count of `b` and not the string length.
- A third and fourth `b`. These separate the overflow trap from the accept state and from a counter that wraps back to zero.
- Idle cycles with `symBit` toggling, and input changes between clock edges. These distinguish a held, Moore-style state from one that leaks the input.
- A reset that arrives together with a valid `b`. This settles which of the two wins at that edge.

// File: rtl/pair_recognizer_pkg.sv
package pair_recognizer_pkg;
  // strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clear;  // force state 0
    logic step;   // consume one symbol
    logic mark;   // consumed symbol is the marked letter
  } ctrlStrobe_t;
endpackage

// File: rtl/pairControl.sv
module pairControl
  import pair_recognizer_pkg::*;
(
  input  logic        rst,
  input  logic        symValid,
  input  logic        symBit,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.clear = rst;
    strobe.step  = symValid & ~rst;
    strobe.mark  = symBit;
  end
endmodule

// File: rtl/pairDatapath.sv
module pairDatapath
  import pair_recognizer_pkg::*;
#(
  parameter int TARGET_COUNT = 2
) (
  input  logic        clk,
  input  ctrlStrobe_t strobe,
  output logic        accept
);
  localparam int NUM_STATES = TARGET_COUNT + 2;
  localparam int STATE_W    = $clog2(NUM_STATES);
  localparam int SLOTS      = 1 << STATE_W;
  localparam logic [STATE_W-1:0] TRAP_STATE   = STATE_W'(NUM_STATES - 1);
  localparam logic [STATE_W-1:0] ACCEPT_STATE = STATE_W'(TARGET_COUNT);

  logic [STATE_W-1:0] curState;
  logic [STATE_W-1:0] perStateNext [SLOTS];
  logic [STATE_W-1:0] selNext;

  // one small next-state function per state
  for (genvar s = 0; s < SLOTS; s++) begin : g_next
    if (s >= NUM_STATES - 1) begin : g_trap
      assign perStateNext[s] = TRAP_STATE;
    end else begin : g_count
      assign perStateNext[s] = strobe.mark ? STATE_W'(s + 1) : STATE_W'(s);
    end
  end

  // multiplexer selected by the current state
  always_comb begin
    selNext = curState;
    if (strobe.step) selNext = perStateNext[curState];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) curState <= '0;
    else              curState <= selNext;
  end

  assign accept = (curState == ACCEPT_STATE);

  p_zero_keeps_r2: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.step && !strobe.mark) |=> $stable(curState));
  p_mark_advances_r3: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.step && strobe.mark && curState != TRAP_STATE) |=> curState == $past(curState) + 1'b1);
  p_trap_absorbs_r5: assert property (@(posedge clk) disable iff (strobe.clear)
    (curState == TRAP_STATE) |=> curState == TRAP_STATE);
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.step |=> $stable(curState));
  p_moore_accept_r7: assert property (@(posedge clk) disable iff (strobe.clear)
    $stable(curState) |-> $stable(accept));
endmodule

// File: rtl/pairRecognizer.sv
module pairRecognizer
  import pair_recognizer_pkg::*;
#(
  parameter int TARGET_COUNT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic symValid,
  input  logic symBit,
  output logic accept
);
  ctrlStrobe_t strobe;

  pairControl u_ctrl (
    .rst(rst), .symValid(symValid), .symBit(symBit), .strobe(strobe)
  );

  pairDatapath #(.TARGET_COUNT(TARGET_COUNT)) u_dp (
    .clk(clk), .strobe(strobe), .accept(accept)
  );

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !accept);
  p_reset_wins_r8: assert property (@(posedge clk) (rst && symValid) |=> !accept);
endmodule

// File: tb/pairRecognizer_bench.sv
`timescale 1ns/1ps
module pairRecognizer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic symValid = 1'b0;
  logic symBit = 1'b0;
  logic accept;
  int vecCount = 0;
  int missCount = 0;
  int bCount = 0;  // bench model: marked symbols since reset

  pairRecognizer u_pairRecognizer (
    .clk(clk), .rst(rst), .symValid(symValid), .symBit(symBit), .accept(accept)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input logic expected, input string req);
    vecCount++;
    if (accept !== expected) begin
      missCount++;
      $display("FAIL %s: accept=%b expected=%b", req, accept, expected);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at next falling edge
  task automatic apply(input logic v, input logic b, input string req);
    symValid = v; symBit = b;
    @(negedge clk);
    if (v && b && bCount < 3) bCount++;
    check(bCount == 2, req);
  endtask

  task automatic doReset(input string req);
    rst = 1'b1; symValid = 1'b0; symBit = 1'b0;
    @(negedge clk);
    rst = 1'b0; bCount = 0;
    check(1'b0, req);
  endtask

  task automatic t_reset();
    doReset("R1");
  endtask

  task automatic t_zeros_keep();
    doReset("R1");
    for (int i = 0; i < 3; i++) apply(1'b1, 1'b0, "R2");
    apply(1'b1, 1'b1, "R3");
    apply(1'b1, 1'b0, "R2");
    apply(1'b1, 1'b1, "R3");
    for (int i = 0; i < 3; i++) apply(1'b1, 1'b0, "R2");
  endtask

  task automatic t_exactly_two();
    doReset("R1");
    apply(1'b1, 1'b1, "R3");
    apply(1'b1, 1'b1, "R3");
  endtask

  task automatic t_overflow();
    doReset("R1");
    repeat (2) apply(1'b1, 1'b1, "R3");
    apply(1'b1, 1'b1, "R4");
  endtask

  task automatic t_trap_absorb();
    doReset("R1");
    repeat (3) apply(1'b1, 1'b1, "R4");
    for (int i = 0; i < 6; i++) apply(1'b1, logic'(i % 2), "R5");
    doReset("R5");
    repeat (2) apply(1'b1, 1'b1, "R5");
  endtask

  task automatic t_valid_low();
    doReset("R1");
    apply(1'b1, 1'b1, "R3");
    for (int i = 0; i < 4; i++) apply(1'b0, 1'b1, "R6");
    apply(1'b1, 1'b1, "R3");
    for (int i = 0; i < 4; i++) apply(1'b0, logic'(i % 2), "R6");
  endtask

  task automatic t_moore();
    doReset("R1");
    repeat (2) apply(1'b1, 1'b1, "R3");
    symValid = 1'b1; symBit = 1'b1;
    #0.5 check(1'b1, "R7");
    symBit = 1'b0;
    #0.5 check(1'b1, "R7");
    symBit = 1'b1;
    @(negedge clk);
    bCount++;
    check(1'b0, "R7");
  endtask

  task automatic t_reset_priority();
    doReset("R1");
    apply(1'b1, 1'b1, "R3");
    rst = 1'b1; symValid = 1'b1; symBit = 1'b1;
    @(negedge clk);
    rst = 1'b0; bCount = 0;
    check(1'b0, "R8");
    apply(1'b1, 1'b1, "R8");
    apply(1'b1, 1'b1, "R8");
  endtask

  initial begin
    #20000;
    missCount++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_zeros_keep();
    t_exactly_two();
    t_overflow();
    t_trap_absorb();
    t_valid_low();
    t_moore();
    t_reset_priority();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule